// File: doc/BRIEF.md
# Phase-Frequency Detector with Stretched Clear

This block compares the rising edges of a reference clock with those of a divided feedback clock and drives pump-up and pump-down pulses for a charge pump. Both inputs are sampled by a fast clock. Each input passes through a two-stage synchronizer, and its rising edges are detected in the fast domain.

In flag mode, the reference edge raises `up_o` and the feedback edge raises `dn_o`. Once both are high, the pair stays high together for a programmed number of extra fast cycles and then both drop in the same cycle. Because both pump branches are fully on before either turns off, the gain does not collapse near zero phase error.

In quadrature mode, each input is halved by a toggle flop. `up_o` carries the XOR of the two halves and `dn_o` carries its complement. This gives a characteristic that stays linear through zero.

Top module: `pfd_delayed_clear`

## Requirements
- R1: While `rst_n` is low, `up_o` and `dn_o` are both 0.
- R2: In flag mode, a rising edge of `ref_in` shows on `up_o` at the third rising `clk` edge after the input goes high. A `ref_in` edge alone leaves `dn_o` low, and `fb_in` edges raise `dn_o` with the same latency.
- R3: In flag mode, once both outputs are high they stay high together for exactly D+1 `clk` cycles, where D is `clr_delay`. They then fall in the same cycle. Every pulse pair ends this way.
- R4: When the reference edge leads by S fast cycles, the `up_o` width is S+D+1 and the `dn_o` width is D+1.
- R5: When the feedback edge leads by S fast cycles, the `dn_o` width is S+D+1 and the `up_o` width is D+1.
- R6: With `clr_delay` = 0, the overlap is a single `clk` cycle, including for simultaneous edges.
- R7: With `mode_xor` = 1, each rising input edge toggles that input's half-rate copy. `up_o` is the XOR of the two copies and `dn_o` is its inverse, so a feedback lag of S cycles gives S high cycles of `up_o` per edge pair.
- R8: A change of `mode_xor` clears both flags, the overlap counter and both half-rate copies in the next `clk` cycle. After entering quadrature mode, `up_o`=0 and `dn_o`=1. After entering flag mode, both are 0.
- R9: Falling edges and held levels on `ref_in` and `fb_in` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| mode_xor | input | 1 | 0 = flag mode, 1 = quadrature XOR mode |
| clr_delay | input | DLY_W (4) | Extra overlap cycles D before the clear |
| up_o | output | 1 | Pump-up drive |
| dn_o | output | 1 | Pump-down drive |

## Verification
On every cycle, the assertions check the following:
- An output in flag mode rises only after a detected edge of its own input.
- An overlapping pair never drops early.
- A fired clear drops both outputs together.
- A mode change leaves `up_o` low.
- The quadrature output only moves on a detected edge.

Only the bench scenarios can show the exact pulse widths and their difference against the edge skew for each lead direction and delay setting. The same applies to the three-cycle input latency and the fact that falling edges leave the outputs untouched.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {
    PFD_FLAG = 1'b0,
    PFD_QUAD = 1'b1
  } pfd_mode_e;

  // Phase word of the quadrature detector from the two half-rate copies.
  function automatic logic quad_phase(input logic ref_half, input logic fb_half);
    return ref_half ^ fb_half;
  endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], din};
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic [DLY_W-1:0] dly,
  output logic             up_q,
  output logic             dn_q,
  output logic             clr_fire,
  output logic [DLY_W-1:0] hold_cnt
);
  logic both;

  function automatic logic hold_done(input logic [DLY_W-1:0] cnt,
                                     input logic [DLY_W-1:0] limit);
    return cnt >= limit;
  endfunction

  assign both     = up_q & dn_q;
  assign clr_fire = both & hold_done(hold_cnt, dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      hold_cnt <= '0;
    end else if (flush) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      hold_cnt <= '0;
    end else begin
      up_q <= ref_rise | (up_q & ~clr_fire);
      dn_q <= fb_rise  | (dn_q & ~clr_fire);
      if (clr_fire || !both) hold_cnt <= '0;
      else                   hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_quad_core.sv
module pfd_quad_core (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic phase
);
  import pfd_pkg::*;
  logic ref_half, fb_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_half <= 1'b0;
      fb_half  <= 1'b0;
    end else if (flush) begin
      ref_half <= 1'b0;
      fb_half  <= 1'b0;
    end else begin
      ref_half <= ref_half ^ ref_rise;
      fb_half  <= fb_half ^ fb_rise;
    end
  end

  assign phase = quad_phase(ref_half, fb_half);
endmodule

// File: rtl/pfd_delayed_clear.sv
module pfd_delayed_clear #(
  parameter int DLY_W     = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic             mode_xor,
  input  logic [DLY_W-1:0] clr_delay,
  output logic             up_o,
  output logic             dn_o
);
  import pfd_pkg::*;

  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_v;
  logic            ref_rise, fb_rise;
  pfd_mode_e       mode_q;
  logic            flush;
  logic            flag_up, flag_dn, clr_fire, quad_ph;
  logic [DLY_W-1:0] hold_cnt;

  assign raw_in = {fb_in, ref_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[i]),
      .rise (rise_v[i])
    );
  end

  assign ref_rise = rise_v[0];
  assign fb_rise  = rise_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PFD_FLAG;
    else        mode_q <= pfd_mode_e'(mode_xor);
  end

  assign flush = (mode_q != pfd_mode_e'(mode_xor));

  pfd_flag_core #(.DLY_W(DLY_W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .ref_rise(ref_rise & (mode_q == PFD_FLAG)),
    .fb_rise (fb_rise & (mode_q == PFD_FLAG)),
    .dly     (clr_delay),
    .up_q    (flag_up),
    .dn_q    (flag_dn),
    .clr_fire(clr_fire),
    .hold_cnt(hold_cnt)
  );

  pfd_quad_core u_quad (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .ref_rise(ref_rise & (mode_q == PFD_QUAD)),
    .fb_rise (fb_rise & (mode_q == PFD_QUAD)),
    .phase   (quad_ph)
  );

  always_comb begin
    if (mode_q == PFD_QUAD) begin
      up_o = quad_ph;
      dn_o = ~quad_ph;
    end else begin
      up_o = flag_up;
      dn_o = flag_dn;
    end
  end
endmodule

// File: rtl/pfd_delayed_clear_chk.sv
module pfd_delayed_clear_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_q,
  input logic             flush,
  input logic             ref_rise,
  input logic             fb_rise,
  input logic             clr_fire,
  input logic [DLY_W-1:0] hold_cnt,
  input logic             up_o,
  input logic             dn_o
);
  // R2: in flag mode an output rises only after its own detected edge
  a_r2_up_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !flush && $rose(up_o)) |-> $past(ref_rise));
  a_r2_dn_from_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !flush && $rose(dn_o)) |-> $past(fb_rise));

  // R3: an overlapping pair holds until the clear fires
  a_r3_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !flush && up_o && dn_o && !clr_fire) |=> (up_o && dn_o));

  // R3: a fired clear drops both outputs in the same cycle
  a_r3_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !flush && clr_fire && !ref_rise && !fb_rise) |=> (!up_o && !dn_o));

  // R3: the overlap counter only runs while both flags are high
  a_r3_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !(up_o && dn_o)) |-> (hold_cnt == '0));

  // R7: the quadrature output moves only on a detected edge
  a_r7_quad_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !flush && !ref_rise && !fb_rise) |=> $stable(up_o));

  // R8: a mode change leaves up_o low
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !up_o);
endmodule

bind pfd_delayed_clear pfd_delayed_clear_chk #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_q  (mode_q),
  .flush   (flush),
  .ref_rise(ref_rise),
  .fb_rise (fb_rise),
  .clr_fire(clr_fire),
  .hold_cnt(hold_cnt),
  .up_o    (up_o),
  .dn_o    (dn_o)
);

// File: tb/pfd_delayed_clear_test.sv
module pfd_delayed_clear_test;
  localparam int CLK_P = 10;
  localparam int DW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_in = 1'b0;
  logic          fb_in = 1'b0;
  logic          mode_xor = 1'b0;
  logic [DW-1:0] clr_delay = '0;
  logic          up_o, dn_o;

  typedef struct {
    int    up_w;
    int    dn_w;
    int    ovl;
    string req;
  } exp_t;

  exp_t  q[$];
  exp_t  e_mon;
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    mon_en  = 1'b0;
  int    cu = 0, cd = 0, cb = 0;

  pfd_delayed_clear #(.DLY_W(DW)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .mode_xor (mode_xor),
    .clr_delay(clr_delay),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: measures each flag-mode pulse pair and compares with the queue.
  always @(negedge clk) begin
    if (!mon_en) begin
      cu = 0; cd = 0; cb = 0;
    end else begin
      if (up_o) cu++;
      if (dn_o) cd++;
      if (up_o && dn_o) cb++;
      if (!up_o && !dn_o && (cu != 0 || cd != 0)) begin
        if (q.size() == 0) begin
          chk("R3 unexpected pulse", 1, 0);
        end else begin
          e_mon = q.pop_front();
          chk({e_mon.req, " up width"}, cu, e_mon.up_w);
          chk({e_mon.req, " dn width"}, cd, e_mon.dn_w);
          chk({e_mon.req, " R3 overlap"}, cb, e_mon.ovl);
        end
        cu = 0; cd = 0; cb = 0;
      end
    end
  end

  // Driver: one flag-mode edge pair with skew s; pushes the expected widths.
  task automatic pair(input int s, input bit ref_lead, input bit lat, input string req);
    int   d;
    exp_t e;
    d     = int'(clr_delay);
    e.up_w = ref_lead ? s + d + 1 : d + 1;
    e.dn_w = ref_lead ? d + 1 : s + d + 1;
    e.ovl  = d + 1;
    e.req  = req;
    q.push_back(e);
    @(negedge clk);
    if (ref_lead) ref_in = 1'b1; else fb_in = 1'b1;
    for (int i = 1; i <= s; i++) begin
      @(negedge clk);
      if (lat && i == 2) chk("R2 up low two cycles after edge", int'(up_o), 0);
      if (lat && i == 3) begin
        chk("R2 up high three cycles after edge", int'(up_o), 1);
        chk("R2 dn low without fb edge", int'(dn_o), 0);
      end
    end
    ref_in = 1'b1;
    fb_in  = 1'b1;
    repeat (s + d + 8) @(negedge clk);
    chk({req, " R9 held levels idle"}, int'(up_o | dn_o), 0);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 falling edges ignored", int'(up_o | dn_o), 0);
  endtask

  // Quadrature pair: fb lags ref by s cycles; up_o must be high s cycles.
  task automatic quad_pair(input int s);
    int hi, bad;
    hi = 0; bad = 0;
    @(negedge clk);
    ref_in = ~ref_in ? 1'b1 : 1'b1;
    for (int i = 1; i <= s + 8; i++) begin
      @(negedge clk);
      if (up_o) hi++;
      if (dn_o == up_o) bad++;
      if (i == s) fb_in = 1'b1;
    end
    chk("R7 quad up width equals lag", hi, s);
    chk("R7 quad dn is inverse of up", bad, 0);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 quad falling edges ignored", int'(up_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 up low in reset", int'(up_o), 0);
    chk("R1 dn low in reset", int'(dn_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    clr_delay = 4'd3;
    pair(6, 1'b1, 1'b1, "R4 ref leads 6");
    pair(2, 1'b1, 1'b0, "R4 ref leads 2");
    pair(5, 1'b0, 1'b0, "R5 fb leads 5");
    pair(0, 1'b1, 1'b0, "R3 simultaneous");
    clr_delay = 4'd0;
    pair(4, 1'b1, 1'b0, "R6 zero delay ref leads");
    pair(0, 1'b0, 1'b0, "R6 zero delay simultaneous");
    clr_delay = 4'd15;
    pair(3, 1'b0, 1'b0, "R3 max delay fb leads");
    chk("R3 every pulse pair seen", q.size(), 0);

    // R8: a mode change flushes a pending flag
    mon_en = 1'b0;
    ref_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 pending up flag", int'(up_o), 1);
    mode_xor = 1'b1;
    @(negedge clk);
    chk("R8 quad entry up", int'(up_o), 0);
    chk("R8 quad entry dn", int'(dn_o), 1);
    mode_xor = 1'b0;
    @(negedge clk);
    chk("R8 flag entry clears up", int'(up_o), 0);
    chk("R8 flag entry clears dn", int'(dn_o), 0);
    ref_in = 1'b0;
    repeat (4) @(negedge clk);

    mode_xor = 1'b1;
    repeat (2) @(negedge clk);
    quad_pair(4);
    quad_pair(4);
    quad_pair(7);

    mode_xor = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 flag mode idle after quad", int'(up_o | dn_o), 0);
    mon_en = 1'b1;
    clr_delay = 4'd2;
    pair(3, 1'b1, 1'b0, "R4 after return to flag mode");
    chk("R3 queue drained", q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule